// File: doc/BRIEF.md
# PWM Output Steering with Dead-Band

This block takes one raw pulse-width-modulated signal and distributes it to four channel outputs, A to D, according to a 2-bit topology selector. It supports driving one output alone, a complementary pair for a half-bridge, and the two diagonal patterns of a full bridge (forward and reverse). Every output is registered, so each one follows its input conditions one clock later.

In half-bridge mode the pair is protected against shoot-through. Before either side turns on, the block waits a programmable number of clocks, given by a 7-bit count. Turning a side off is never delayed. If the count is longer than the time a side would be on, that side stays off for the whole interval. The delay is applied only in half-bridge mode. In every other topology, outputs turn on one clock after their request.

Top module: `pwm_steer`

## Requirements
- R1: While reset is asserted, and when reset has just been released, all four outputs are low.
- R2: With topology code 0 (single), channel A follows the PWM input and channels B, C and D are low.
- R3: With topology code 1 (half-bridge), channel A carries the PWM input and channel B carries its inverse, with C and D low.
- R4: With topology code 2 (bridge forward), channel A is high, channel D follows the PWM input, and B and C are low.
- R5: With topology code 3 (bridge reverse), channel C is high, channel B follows the PWM input, and A and D are low.
- R6: In half-bridge mode, with a dead-band count N, a side whose request has just gone high goes high N+1 clocks after the request was first sampled.
- R7: A side whose request goes low goes low on the next clock edge, with no dead-band wait.
- R8: In half-bridge mode, if a side's request stays high for N clocks or fewer, that side never goes high during the interval.
- R9: A dead-band count of zero adds no wait, so an output rises one clock after its request.
- R10: Channels A and B are never high at the same time.
- R11: Outside half-bridge mode, the dead-band count has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pwm_in | input | 1 | Raw PWM signal |
| topo | input | 2 | Topology: 0 single, 1 half-bridge, 2 bridge forward, 3 bridge reverse |
| dead_cnt | input | 7 | Dead-band wait in clocks, used in half-bridge mode only |
| ch_a | output | 1 | Channel A |
| ch_b | output | 1 | Channel B |
| ch_c | output | 1 | Channel C |
| ch_d | output | 1 | Channel D |

## Verification
The hardest case to reach is the boundary of dead-band suppression. Here a request lasts exactly as many clocks as the count, or one clock more, so the output must stay low in the first case and pulse for a single clock in the second. The stimulus builds PWM high phases of measured length around a count of five, and checks the output after every clock. The return edge is also covered: B's rising is delayed after PWM falls. The bench watches for A/B overlap on every cycle throughout.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;
  typedef enum logic [1:0] {
    TOPO_SINGLE = 2'd0,
    TOPO_HALF   = 2'd1,
    TOPO_FWD    = 2'd2,
    TOPO_REV    = 2'd3
  } topo_e;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/pwm_db_cell.sv
module pwm_db_cell #(
  parameter int DLY_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [DLY_W-1:0] dly,
  output logic             drv
);
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             drv_q, drv_d;

  always_comb begin
    cnt_d = cnt_q;
    drv_d = drv_q;
    if (!req) begin
      cnt_d = '0;
      drv_d = 1'b0;
    end else if (drv_q || (cnt_q >= dly)) begin
      drv_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      drv_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      drv_q <= drv_d;
    end
  end

  assign drv = drv_q;

  assert_fall_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !drv_q);
  assert_zero_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && dly == '0) |=> drv_q);
  assert_rise_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_q) |-> $past(req));
endmodule

// File: rtl/pwm_steer.sv
module pwm_steer #(
  parameter int DLY_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic [1:0]       topo,
  input  logic [DLY_W-1:0] dead_cnt,
  output logic             ch_a,
  output logic             ch_b,
  output logic             ch_c,
  output logic             ch_d
);
  import pwm_steer_pkg::*;

  localparam int NCH = 4;
  localparam int NDB = 2;

  logic             rst_s;
  logic [NCH-1:0]   req;
  logic [NCH-1:0]   drv;
  logic [DLY_W-1:0] half_dly;
  topo_e            tsel;

  pwm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s)
  );

  assign tsel = topo_e'(topo);

  always_comb begin
    req = '0;
    unique case (tsel)
      TOPO_SINGLE: req[0] = pwm_in;
      TOPO_HALF: begin
        req[0] = pwm_in;
        req[1] = !pwm_in;
      end
      TOPO_FWD: begin
        req[0] = 1'b1;
        req[3] = pwm_in;
      end
      TOPO_REV: begin
        req[1] = pwm_in;
        req[2] = 1'b1;
      end
      default: req = '0;
    endcase
  end

  assign half_dly = (tsel == TOPO_HALF) ? dead_cnt : '0;

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    if (i < NDB) begin : g_db
      pwm_db_cell #(.DLY_W(DLY_W)) u_cell (
        .clk(clk), .rst_n(rst_s), .req(req[i]), .dly(half_dly), .drv(drv[i])
      );
    end else begin : g_plain
      pwm_db_cell #(.DLY_W(DLY_W)) u_cell (
        .clk(clk), .rst_n(rst_s), .req(req[i]), .dly('0), .drv(drv[i])
      );
    end
  end

  assign ch_a = drv[0];
  assign ch_b = drv[1];
  assign ch_c = drv[2];
  assign ch_d = drv[3];

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_s)
    !(ch_a && ch_b));
  assert_c_rev_only_R5: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(topo) != 2'd3) |-> !ch_c);
  assert_d_fwd_only_R4: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(topo) != 2'd2) |-> !ch_d);
  assert_reset_low_R1: assert property (@(posedge clk)
    (rst_n && !rst_s) |-> !(ch_a || ch_b || ch_c || ch_d));
endmodule

// File: tb/pwm_steer_test.sv
module pwm_steer_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwm_in;
  logic [1:0] topo;
  logic [6:0] dead_cnt;
  logic       ch_a, ch_b, ch_c, ch_d;
  int         checks = 0;
  int         errors = 0;
  int         overlaps = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_steer uut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .topo(topo), .dead_cnt(dead_cnt),
    .ch_a(ch_a), .ch_b(ch_b), .ch_c(ch_c), .ch_d(ch_d)
  );

  // {topo[1:0], pwm, expected a,b,c,d}
  localparam logic [6:0] VEC [8] = '{
    7'b00_0_0000, 7'b00_1_1000, 7'b01_0_0100, 7'b01_1_1000,
    7'b10_0_1000, 7'b10_1_1001, 7'b11_0_0010, 7'b11_1_0110
  };

  always @(negedge clk) if (rst_n && ch_a && ch_b) overlaps++;

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {ch_a, ch_b, ch_c, ch_d};
  endfunction

  initial begin
    #100us;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pwm_in = 1'b1; topo = 2'd2; dead_cnt = 7'd0;
    step(3);
    chk("R1 in reset", outs(), 4'b0000);
    rst_n = 1'b1;
    step(1);
    chk("R1 after release", outs(), 4'b0000);
    pwm_in = 1'b0; topo = 2'd0;
    step(3);

    // table walk, dead-band zero (R2 R3 R4 R5 R9)
    for (int v = 0; v < 8; v++) begin
      topo = VEC[v][6:5];
      pwm_in = VEC[v][4];
      step(2);
      chk($sformatf("R2-5 vector %0d (R9)", v), outs(), VEC[v][3:0]);
    end

    // R9: rise one clock after the request with zero count
    topo = 2'd1; dead_cnt = 7'd0; pwm_in = 1'b0;
    step(3);
    pwm_in = 1'b1;
    step(1);
    chk("R9 zero wait", outs(), 4'b1000);

    // R6/R7: half-bridge, count 3
    pwm_in = 1'b0; dead_cnt = 7'd3;
    step(6);
    chk("R3 B high before edge", outs(), 4'b0100);
    pwm_in = 1'b1;
    step(1);
    chk("R7 B falls next clock", outs(), 4'b0000);
    step(2);
    chk("R6 A still waiting", outs(), 4'b0000);
    step(1);
    chk("R6 A rises at N+1", outs(), 4'b1000);
    step(4);
    pwm_in = 1'b0;
    step(1);
    chk("R7 A falls next clock", outs(), 4'b0000);
    step(2);
    chk("R6 B still waiting", outs(), 4'b0000);
    step(1);
    chk("R6 B rises at N+1", outs(), 4'b0100);

    // R8: active time equal to the count suppresses the side
    dead_cnt = 7'd5;
    step(3);
    pwm_in = 1'b1;
    for (int k = 0; k < 5; k++) begin
      step(1);
      chk($sformatf("R8 suppressed clock %0d", k), outs(), 4'b0000);
    end
    pwm_in = 1'b0;
    step(1);
    chk("R8 after short pulse", outs(), 4'b0000);
    step(6);
    // one clock longer: single-clock pulse
    pwm_in = 1'b1;
    step(6);
    pwm_in = 1'b0;
    chk("R8 boundary plus one rises", outs(), 4'b1000);
    step(1);
    chk("R8 boundary plus one falls", outs(), 4'b0000);

    // R11: count ignored in single and forward topologies
    topo = 2'd0; dead_cnt = 7'd100; pwm_in = 1'b0;
    step(3);
    pwm_in = 1'b1;
    step(1);
    chk("R11 single ignores count", outs(), 4'b1000);
    topo = 2'd2; pwm_in = 1'b0;
    step(3);
    pwm_in = 1'b1;
    step(1);
    chk("R11 forward ignores count", outs(), 4'b1001);

    // R1: reset in the middle of operation
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", outs(), 4'b0000);
    step(2);
    rst_n = 1'b1;
    step(1);
    chk("R1 held during sync release", outs(), 4'b0000);

    checks++;
    if (overlaps != 0) begin
      errors++;
      $display("FAIL R10 overlap: got %0d expected 0", overlaps);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule